// File: doc/BRIEF.md
# Single-Level Page Table Walker

This block resolves a translation miss in hardware. When the TLB reports a miss, the walker takes the virtual page number of the missing address and adds it, scaled by the entry size, to a page-table base register that holds the start of the active process's table in physical memory. It then issues one read for the table entry over a valid/ready request channel and waits for a response strobe that carries the 32-bit entry.

If the entry's present bit is set, the walker emits a one-cycle refill pulse that carries the virtual page number, the physical page number and the two-bit rights field, so that the TLB can install the mapping and the access can be retried. If the present bit is clear, no translation is produced. The walker instead emits a one-cycle fault pulse and holds the faulting virtual address in a register that software can read. The walker handles one miss at a time and keeps `busy` high for the whole walk. Software switches process tables by writing the base register. A walk that is already running keeps the base it started with.

Top module: `pt_walker`

## Requirements
- R1: After a synchronous reset, `busy`, `mem_req_valid`, `refill_valid` and `fault_valid` are low, and `base_q` and `fault_va` read zero.
- R2: A cycle with `base_wr_en` high loads `base_wr_data` into the base register, and `base_q` shows the new value from the following cycle.
- R3: The entry address on `mem_req_addr` equals `base_q + (VPN << 2)` modulo 2^32. The VPN is `miss_va[31:12]`, and `base_q` is the value held in the cycle the miss is accepted.
- R4: `mem_req_valid` rises in the cycle after a miss is accepted. It stays high with an unchanged address until a cycle with `mem_req_ready` high, and then drops in the next cycle.
- R5: When the response entry has bit 31 set, the walker pulses `refill_valid` for exactly one cycle, in the cycle after the response. The pulse carries `refill_ppn` = entry bits 21:0, `refill_rights` = entry bits 30:29 and `refill_vpn` = the VPN of the miss.
- R6: When the response entry has bit 31 clear, the walker pulses `fault_valid` for exactly one cycle, in the cycle after the response, and loads `fault_va` with the full missing virtual address. `fault_va` holds that value until the next fault.
- R7: `busy` is high from the cycle after the miss is accepted up to and including the refill or fault pulse, and low in the cycle after it. A `miss_valid` raised while `busy` is high is ignored and starts no further request.
- R8: A base write made during a walk does not change that walk's entry address. The next walk uses the new base.
- R9: `mem_rsp_valid` is ignored unless the walker is waiting for a response after its request was accepted.
- R10: `refill_valid` and `fault_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr_en | input | 1 | Write strobe for the page-table base register |
| base_wr_data | input | 32 | New base address |
| base_q | output | 32 | Current base register value |
| miss_valid | input | 1 | Translation miss request |
| miss_va | input | 32 | Virtual address that missed |
| busy | output | 1 | A walk is in progress |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 32 | Physical address of the table entry |
| mem_rsp_valid | input | 1 | Response strobe |
| mem_rsp_data | input | 32 | Table entry read from memory |
| refill_valid | output | 1 | One-cycle refill pulse to the TLB |
| refill_vpn | output | 20 | Virtual page number of the refill |
| refill_ppn | output | 22 | Physical page number of the refill |
| refill_rights | output | 2 | Access rights of the refill |
| fault_valid | output | 1 | One-cycle page-fault pulse |
| fault_va | output | 32 | Last faulting virtual address |

## Verification
The bench stretches the request handshake by several stall cycles. A walker that let its address drift, or that advanced without seeing ready, would show a moved address or a dropped request. It injects a stray response strobe before the request is accepted, carrying the inverted entry, and one while the walker is idle. A design that took either would end the walk early or pulse with the wrong fields. It raises a second miss and a base write in the middle of a walk. A design that re-armed, or that re-read the base, would issue a second request or use the wrong entry address. Random entries mix present and absent pages, so a walker that confused refill with fault, or failed to keep `fault_va` across refills, gives wrong outputs.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_REQ  = 2'd1,
    WS_WAIT = 2'd2,
    WS_DONE = 2'd3
  } walk_state_e;
endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_data,
  output logic [AW-1:0] base_q
);
  always_ff @(posedge clk) begin
    if (rst)        base_q <= '0;
    else if (wr_en) base_q <= wr_data;
  end
endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int AW          = 32,
  parameter int VPN_W       = 20,
  parameter int ENTRY_BYTES = 4
) (
  input  logic [AW-1:0]    base,
  input  logic [VPN_W-1:0] vpn,
  output logic [AW-1:0]    entry_addr
);
  localparam int SHIFT = $clog2(ENTRY_BYTES);
  logic [AW-1:0] scaled;

  generate
    if (SHIFT == 0) begin : g_noscale
      assign scaled = AW'(vpn);
    end else begin : g_scale
      assign scaled = AW'(vpn) << SHIFT;
    end
  endgenerate

  assign entry_addr = base + scaled;
endmodule

// File: rtl/ptw_pte_decode.sv
module ptw_pte_decode #(
  parameter int PTE_W      = 32,
  parameter int PPN_W      = 22,
  parameter int RIGHTS_W   = 2,
  parameter int VALID_POS  = 31,
  parameter int RIGHTS_LSB = 29
) (
  input  logic [PTE_W-1:0]    pte,
  output logic                present,
  output logic [RIGHTS_W-1:0] rights,
  output logic [PPN_W-1:0]    ppn
);
  assign present = pte[VALID_POS];
  assign rights  = pte[RIGHTS_LSB +: RIGHTS_W];
  assign ppn     = PPN_W'(pte);
endmodule

// File: rtl/ptw_ctrl.sv
module ptw_ctrl
  import ptw_pkg::*;
#(
  parameter int AW       = 32,
  parameter int VA_W     = 32,
  parameter int VPN_W    = 20,
  parameter int PPN_W    = 22,
  parameter int RIGHTS_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                miss_valid,
  input  logic [VA_W-1:0]     miss_va,
  input  logic [AW-1:0]       entry_addr,
  output logic                busy,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [AW-1:0]       req_addr,
  input  logic                rsp_valid,
  input  logic                pte_present,
  input  logic [RIGHTS_W-1:0] pte_rights,
  input  logic [PPN_W-1:0]    pte_ppn,
  output logic                refill_valid,
  output logic [VPN_W-1:0]    refill_vpn,
  output logic [PPN_W-1:0]    refill_ppn,
  output logic [RIGHTS_W-1:0] refill_rights,
  output logic                fault_valid,
  output logic [VA_W-1:0]     fault_va
);
  walk_state_e   state;
  logic [VA_W-1:0] va_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= WS_IDLE;
      va_q          <= '0;
      req_addr      <= '0;
      refill_valid  <= 1'b0;
      refill_vpn    <= '0;
      refill_ppn    <= '0;
      refill_rights <= '0;
      fault_valid   <= 1'b0;
      fault_va      <= '0;
    end else begin
      refill_valid <= 1'b0;
      fault_valid  <= 1'b0;
      unique case (state)
        WS_IDLE: begin
          if (miss_valid) begin
            va_q     <= miss_va;
            req_addr <= entry_addr;
            state    <= WS_REQ;
          end
        end
        WS_REQ: begin
          if (req_ready) state <= WS_WAIT;
        end
        WS_WAIT: begin
          if (rsp_valid) begin
            state <= WS_DONE;
            if (pte_present) begin
              refill_valid  <= 1'b1;
              refill_vpn    <= va_q[VA_W-1 -: VPN_W];
              refill_ppn    <= pte_ppn;
              refill_rights <= pte_rights;
            end else begin
              fault_valid <= 1'b1;
              fault_va    <= va_q;
            end
          end
        end
        WS_DONE: state <= WS_IDLE;
        default: state <= WS_IDLE;
      endcase
    end
  end

  assign busy      = (state != WS_IDLE);
  assign req_valid = (state == WS_REQ);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int AW          = 32,
  parameter int VA_W        = 32,
  parameter int PAGE_OFF_W  = 12,
  parameter int PTE_W       = 32,
  parameter int PPN_W       = 22,
  parameter int RIGHTS_W    = 2,
  parameter int VALID_POS   = 31,
  parameter int RIGHTS_LSB  = 29,
  parameter int ENTRY_BYTES = 4,
  parameter int VPN_W       = VA_W - PAGE_OFF_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                base_wr_en,
  input  logic [AW-1:0]       base_wr_data,
  output logic [AW-1:0]       base_q,
  input  logic                miss_valid,
  input  logic [VA_W-1:0]     miss_va,
  output logic                busy,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic [AW-1:0]       mem_req_addr,
  input  logic                mem_rsp_valid,
  input  logic [PTE_W-1:0]    mem_rsp_data,
  output logic                refill_valid,
  output logic [VPN_W-1:0]    refill_vpn,
  output logic [PPN_W-1:0]    refill_ppn,
  output logic [RIGHTS_W-1:0] refill_rights,
  output logic                fault_valid,
  output logic [VA_W-1:0]     fault_va
);
  logic [AW-1:0]       entry_addr;
  logic                pte_present;
  logic [RIGHTS_W-1:0] pte_rights;
  logic [PPN_W-1:0]    pte_ppn;

  ptw_base_reg #(.AW(AW)) u_base (
    .clk(clk), .rst(rst), .wr_en(base_wr_en),
    .wr_data(base_wr_data), .base_q(base_q)
  );

  ptw_addr_gen #(.AW(AW), .VPN_W(VPN_W), .ENTRY_BYTES(ENTRY_BYTES)) u_addr (
    .base(base_q), .vpn(miss_va[VA_W-1 -: VPN_W]), .entry_addr(entry_addr)
  );

  ptw_pte_decode #(
    .PTE_W(PTE_W), .PPN_W(PPN_W), .RIGHTS_W(RIGHTS_W),
    .VALID_POS(VALID_POS), .RIGHTS_LSB(RIGHTS_LSB)
  ) u_dec (
    .pte(mem_rsp_data), .present(pte_present),
    .rights(pte_rights), .ppn(pte_ppn)
  );

  ptw_ctrl #(
    .AW(AW), .VA_W(VA_W), .VPN_W(VPN_W), .PPN_W(PPN_W), .RIGHTS_W(RIGHTS_W)
  ) u_ctrl (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_va(miss_va), .entry_addr(entry_addr),
    .busy(busy), .req_valid(mem_req_valid), .req_ready(mem_req_ready),
    .req_addr(mem_req_addr), .rsp_valid(mem_rsp_valid),
    .pte_present(pte_present), .pte_rights(pte_rights), .pte_ppn(pte_ppn),
    .refill_valid(refill_valid), .refill_vpn(refill_vpn),
    .refill_ppn(refill_ppn), .refill_rights(refill_rights),
    .fault_valid(fault_valid), .fault_va(fault_va)
  );
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          base_wr_en,
  input logic [AW-1:0] base_wr_data,
  input logic [AW-1:0] base_q,
  input logic          busy,
  input logic          req_valid,
  input logic          req_ready,
  input logic [AW-1:0] req_addr,
  input logic          refill_valid,
  input logic          fault_valid
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  always @(posedge clk) begin
    if (rst_d && !rst) begin
      assert_reset_idle_R1: assert (!busy && !req_valid && !refill_valid && !fault_valid && base_q == '0)
        else $error("R1 outputs not idle after reset");
    end
  end

  assert_base_load_R2: assert property (@(posedge clk) disable iff (rst)
    base_wr_en |=> base_q == $past(base_wr_data));

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  assert_req_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_valid);

  assert_refill_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    refill_valid |=> !refill_valid);

  assert_fault_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    fault_valid |=> !fault_valid);

  assert_req_busy_R7: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> busy);

  assert_pulse_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (refill_valid || fault_valid) |-> busy);

  assert_pulse_ends_R7: assert property (@(posedge clk) disable iff (rst)
    (refill_valid || fault_valid) |=> !busy);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    !(refill_valid && fault_valid));
endmodule

bind pt_walker ptw_checker #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
  .base_q(base_q), .busy(busy), .req_valid(mem_req_valid),
  .req_ready(mem_req_ready), .req_addr(mem_req_addr),
  .refill_valid(refill_valid), .fault_valid(fault_valid)
);

// File: tb/sim_pt_walker.sv
module sim_pt_walker;
  logic        clk = 1'b0;
  logic        rst;
  logic        base_wr_en;
  logic [31:0] base_wr_data;
  logic [31:0] base_q;
  logic        miss_valid;
  logic [31:0] miss_va;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        refill_valid;
  logic [19:0] refill_vpn;
  logic [21:0] refill_ppn;
  logic [1:0]  refill_rights;
  logic        fault_valid;
  logic [31:0] fault_va;

  pt_walker u0 (
    .clk(clk), .rst(rst), .base_wr_en(base_wr_en), .base_wr_data(base_wr_data),
    .base_q(base_q), .miss_valid(miss_valid), .miss_va(miss_va), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .refill_valid(refill_valid),
    .refill_vpn(refill_vpn), .refill_ppn(refill_ppn),
    .refill_rights(refill_rights), .fault_valid(fault_valid), .fault_va(fault_va)
  );

  always #10 clk = ~clk;

  int          errors = 0;
  int          checks = 0;
  bit          finished = 1'b0;
  logic [31:0] cur_base = '0;
  logic [31:0] last_fault = '0;

  function automatic logic [31:0] entry_addr_of(logic [31:0] base, logic [31:0] va);
    return base + ({12'd0, va[31:12]} << 2);
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic set_base(logic [31:0] b);
    @(negedge clk);
    base_wr_en = 1'b1; base_wr_data = b;
    @(negedge clk);
    base_wr_en = 1'b0;
    chk("R2", "base_q", base_q, b);
    cur_base = b;
  endtask

  task automatic walk(logic [31:0] va, logic [31:0] pte, int hold, int lat,
                      bit stray, bit late_miss, bit mid_base, logic [31:0] new_base,
                      string atag);
    logic [31:0] exp_addr;
    exp_addr = entry_addr_of(cur_base, va);
    @(negedge clk);
    miss_valid = 1'b1; miss_va = va;
    @(negedge clk);
    miss_valid = 1'b0;
    chk("R7", "busy after accept", busy, 1);
    chk("R4", "req_valid raised", mem_req_valid, 1);
    chk(atag, "entry address", mem_req_addr, exp_addr);
    for (int i = 0; i < hold; i++) begin
      if (stray && i == 0) begin mem_rsp_valid = 1'b1; mem_rsp_data = ~pte; end
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (stray && i == 0) chk("R9", "early response ignored", refill_valid | fault_valid, 0);
      chk("R4", "req held", mem_req_valid, 1);
      chk("R4", "addr held", mem_req_addr, exp_addr);
    end
    mem_req_ready = 1'b1;
    @(negedge clk);
    mem_req_ready = 1'b0;
    chk("R4", "req dropped after ready", mem_req_valid, 0);
    if (late_miss) begin miss_valid = 1'b1; miss_va = va ^ 32'hFFFF_F000; end
    if (mid_base) begin base_wr_en = 1'b1; base_wr_data = new_base; end
    @(negedge clk);
    miss_valid = 1'b0; base_wr_en = 1'b0;
    if (late_miss) chk("R7", "second miss starts no request", mem_req_valid, 0);
    if (mid_base) chk("R2", "base written mid walk", base_q, new_base);
    repeat (lat) @(negedge clk);
    mem_rsp_valid = 1'b1; mem_rsp_data = pte;
    @(negedge clk);
    mem_rsp_valid = 1'b0;
    chk("R7", "busy on pulse", busy, 1);
    chk("R10", "pulses exclusive", refill_valid & fault_valid, 0);
    if (pte[31]) begin
      chk("R5", "refill_valid", refill_valid, 1);
      chk("R5", "refill_ppn", refill_ppn, pte[21:0]);
      chk("R5", "refill_rights", refill_rights, pte[30:29]);
      chk("R5", "refill_vpn", refill_vpn, va[31:12]);
    end else begin
      chk("R6", "fault_valid", fault_valid, 1);
      chk("R6", "no refill on fault", refill_valid, 0);
      chk("R6", "fault_va", fault_va, va);
      last_fault = va;
    end
    @(negedge clk);
    chk("R5", "refill one cycle", refill_valid, 0);
    chk("R6", "fault one cycle", fault_valid, 0);
    chk("R7", "busy cleared", busy, 0);
    chk("R7", "no new request", mem_req_valid, 0);
    chk("R6", "fault_va held", fault_va, last_fault);
    if (mid_base) cur_base = new_base;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: run hung actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    rst = 1'b1; base_wr_en = 0; base_wr_data = 0; miss_valid = 0; miss_va = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1", "busy", busy, 0);
    chk("R1", "req_valid", mem_req_valid, 0);
    chk("R1", "pulses", refill_valid | fault_valid, 0);
    chk("R1", "base_q", base_q, 0);
    chk("R1", "fault_va", fault_va, 0);

    set_base(32'h0040_0000);
    // present page, no stalls
    walk(32'h1234_5678, 32'hC012_3456, 0, 0, 0, 0, 0, 0, "R3");
    // absent page with stalls and a stray early response
    walk(32'hABCD_E123, 32'h7FFF_FFFF, 3, 2, 1, 0, 0, 0, "R3");
    // R9: response strobe while idle
    @(negedge clk); mem_rsp_valid = 1'b1; mem_rsp_data = 32'h8000_0001;
    @(negedge clk); mem_rsp_valid = 1'b0;
    chk("R9", "idle response ignored", refill_valid | fault_valid | busy, 0);
    // R8: base write during a walk, second miss ignored
    walk(32'h0000_1000, 32'hA000_0001, 1, 1, 0, 1, 1, 32'h0100_0000, "R8");
    walk(32'h0000_1000, 32'h0000_0000, 0, 0, 0, 0, 0, 0, "R8");
    // wrap of the entry address
    set_base(32'hFFFF_FFF0);
    walk(32'hFFFF_F000, 32'hE03F_FFFF, 2, 0, 0, 0, 0, 0, "R3");
    set_base(32'h0020_0000);
    for (int n = 0; n < 60; n++) begin
      logic [31:0] va, pte;
      va = $urandom; pte = $urandom;
      walk(va, pte, $urandom_range(0, 3), $urandom_range(0, 3),
           ($urandom_range(0, 3) == 0), ($urandom_range(0, 3) == 0),
           ($urandom_range(0, 4) == 0), $urandom, "R3");
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule